// File: doc/BRIEF.md
# Oversampling Baud Rate Generator

This block derives the timing of a serial port from the system clock. Two cascaded programmable dividers, a prescaler stage and a divisor stage, produce a sample tick at sixteen times the serial bit rate. A fixed oversampling counter then marks every sixteenth sample tick as the boundary of one bit period. The serial bit rate is therefore the clock frequency divided by 16, divided again by the product of the divisor value and the prescaler value.

The divisor and prescaler inputs are taken into working copies only while the configuration lock input is low. Software or a line controller raises the lock while a character is moving, so a rate change can never tear a bit in half. When a new value is taken, every counter restarts so that the next tick follows the new period exactly. A divisor of zero parks the generator, and a prescaler of zero behaves like one.

Top module: `ovs_baud_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `sample_tick` and `bit_stb` are low, and the working divisor and prescaler are zero, which keeps the generator stopped.
- R2: With working divisor D (non-zero) and prescaler P, `sample_tick` is a one-clock pulse that repeats every D*max(P,1) clocks.
- R3: `bit_stb` is high for one clock together with every 16th `sample_tick` counted since the last restart, so it repeats every 16*D*max(P,1) clocks.
- R4: A working divisor of zero produces no `sample_tick` and no `bit_stb`.
- R5: A prescaler value of zero gives the same period as a prescaler value of one.
- R6: When lock is low and `div_val` or `pre_val` differs from the working copy, the new values are taken at that clock edge, both outputs are low after it, and the first `sample_tick` appears exactly D*max(P,1) clocks after that edge.
- R7: While `cfg_lock` is high, changes on `div_val` and `pre_val` have no effect on the tick period; after lock falls, any pending difference is taken as in R6.
- R8: With divisor 1 and prescaler 1 (or 0), `sample_tick` is high on every clock and `bit_stb` once every 16 clocks, the highest usable rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W (16) | Requested divisor |
| pre_val | input | PRE_W (4) | Requested prescaler, 0 acts as 1 |
| cfg_lock | input | 1 | High holds the working divisor and prescaler |
| sample_tick | output | 1 | One-clock pulse at 16x the bit rate |
| bit_stb | output | 1 | One-clock pulse at each bit-period boundary |

## Verification
The bench builds the block with its default widths (16-bit divisor, 4-bit prescaler, 16x oversampling, prescaler stage present). Small divisor and prescaler values keep whole bit periods within a few hundred clocks, which brings into reach the full-rate case of one tick per clock, the zero prescaler, the zero divisor, mid-period reloads and the behaviour of a change held back by the lock and applied on release. A behavioural model that tracks one elapsed-clock count against the product of the two values is compared with the outputs on every clock, alongside direct measurement of the tick and strobe spacing and of the reload latency.

// File: rtl/baud_pkg.sv
package baud_pkg;
   // Operating state of the generator for the current clock.
   typedef enum logic [1:0] {
      RUN_STOP   = 2'd0,   // working divisor is zero
      RUN_RELOAD = 2'd1,   // new configuration taken this edge
      RUN_COUNT  = 2'd2    // counters advance
   } run_mode_e;

   localparam int unsigned DEF_OVS = 16;
endpackage

// File: rtl/baud_cfg_latch.sv
module baud_cfg_latch
   import baud_pkg::*;
#(
   parameter int unsigned DIV_W = 16,
   parameter int unsigned PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic [PRE_W-1:0] pre_val,
   input  logic             cfg_lock,
   output logic [DIV_W-1:0] act_div,
   output logic [PRE_W-1:0] act_pre,
   output run_mode_e        mode
);
   logic differs;

   assign differs = (div_val != act_div) || (pre_val != act_pre);

   always_comb begin
      if (!cfg_lock && differs)  mode = RUN_RELOAD;
      else if (act_div == '0)    mode = RUN_STOP;
      else                       mode = RUN_COUNT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_div <= '0;
         act_pre <= '0;
      end else if (mode == RUN_RELOAD) begin
         act_div <= div_val;
         act_pre <= pre_val;
      end
   end
endmodule

// File: rtl/baud_stage_cnt.sv
module baud_stage_cnt #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] limit,
   output logic         wrap
);
   logic [W-1:0] cnt;

   // limit is the stage modulus; the stage is only enabled with limit >= 1
   assign wrap = en && (cnt == limit - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (en)     cnt <= wrap ? '0 : cnt + W'(1);
   end
endmodule

// File: rtl/baud_ovs_cnt.sv
module baud_ovs_cnt #(
   parameter int unsigned OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick_ev,
   output logic sample_tick,
   output logic bit_stb
);
   localparam int unsigned SC_W = (OVS > 1) ? $clog2(OVS) : 1;
   localparam logic [SC_W-1:0] LAST = SC_W'(OVS - 1);

   logic [SC_W-1:0] scnt;
   logic            last_slot;

   assign last_slot = (scnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scnt        <= '0;
         sample_tick <= 1'b0;
         bit_stb     <= 1'b0;
      end else if (clr) begin
         scnt        <= '0;
         sample_tick <= 1'b0;
         bit_stb     <= 1'b0;
      end else begin
         sample_tick <= tick_ev;
         bit_stb     <= tick_ev && last_slot;
         if (tick_ev) scnt <= last_slot ? '0 : scnt + SC_W'(1);
      end
   end
endmodule

// File: rtl/ovs_baud_gen.sv
module ovs_baud_gen
   import baud_pkg::*;
#(
   parameter int unsigned DIV_W        = 16,
   parameter int unsigned PRE_W        = 4,
   parameter int unsigned OVS          = DEF_OVS,
   parameter bit          USE_PRESCALE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic [PRE_W-1:0] pre_val,
   input  logic             cfg_lock,
   output logic             sample_tick,
   output logic             bit_stb
);
   // elaboration-time parameter checks
   if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div
      $error("ovs_baud_gen: DIV_W must be 1..32");
   end
   if (PRE_W < 1 || PRE_W > 8) begin : g_bad_pre
      $error("ovs_baud_gen: PRE_W must be 1..8");
   end
   if (OVS < 2) begin : g_bad_ovs
      $error("ovs_baud_gen: OVS must be at least 2");
   end

   logic [DIV_W-1:0] act_div;
   logic [PRE_W-1:0] act_pre;
   run_mode_e        mode;
   logic             reload;
   logic             running;
   logic             pre_wrap;
   logic             div_wrap;

   baud_cfg_latch #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_val  (div_val),
      .pre_val  (pre_val),
      .cfg_lock (cfg_lock),
      .act_div  (act_div),
      .act_pre  (act_pre),
      .mode     (mode)
   );

   assign reload  = (mode == RUN_RELOAD);
   assign running = (mode == RUN_COUNT);

   if (USE_PRESCALE) begin : g_pre
      logic [PRE_W-1:0] pre_lim;
      assign pre_lim = (act_pre == '0) ? PRE_W'(1) : act_pre;

      baud_stage_cnt #(.W(PRE_W)) u_pre (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (reload),
         .en    (running),
         .limit (pre_lim),
         .wrap  (pre_wrap)
      );
   end else begin : g_nopre
      assign pre_wrap = running;
   end

   baud_stage_cnt #(.W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (reload),
      .en    (pre_wrap),
      .limit (act_div),
      .wrap  (div_wrap)
   );

   baud_ovs_cnt #(.OVS(OVS)) u_ovs (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (reload),
      .tick_ev     (div_wrap),
      .sample_tick (sample_tick),
      .bit_stb     (bit_stb)
   );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
   parameter int unsigned DIV_W        = 16,
   parameter int unsigned PRE_W        = 4,
   parameter bit          USE_PRESCALE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_lock,
   input logic             sample_tick,
   input logic             bit_stb,
   input logic [DIV_W-1:0] act_div,
   input logic [PRE_W-1:0] act_pre,
   input logic             reload
);
   logic unit_period;
   assign unit_period = (act_div == DIV_W'(1)) &&
                        (!USE_PRESCALE || act_pre <= PRE_W'(1));

   // R2: a period longer than one clock leaves a gap after each tick
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && !unit_period && !reload) |=> !sample_tick);

   // R3: a bit strobe only ever comes with a sample tick
   p_bit_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> sample_tick);

   // R3: bit strobe is a single-clock pulse
   p_bit_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |=> !bit_stb);

   // R4: a zero working divisor yields no tick
   p_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_div == '0) |=> !sample_tick);

   // R6: both outputs are quiet right after a reload
   p_reload_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (!sample_tick && !bit_stb));

   // R7: working configuration frozen while locked
   p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_lock |=> ($stable(act_div) && $stable(act_pre)));
endmodule

bind ovs_baud_gen baud_gen_chk #(
   .DIV_W        (DIV_W),
   .PRE_W        (PRE_W),
   .USE_PRESCALE (USE_PRESCALE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_lock    (cfg_lock),
   .sample_tick (sample_tick),
   .bit_stb     (bit_stb),
   .act_div     (act_div),
   .act_pre     (act_pre),
   .reload      (reload)
);

// File: tb/ovs_baud_gen_test.sv
`timescale 1ns/1ps
module ovs_baud_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] dv = '0;
   logic [3:0]  pv = '0;
   logic        lock = 1'b0;
   logic        sample_tick;
   logic        bit_stb;

   int errors = 0;
   int checks = 0;
   string cur = "R1";

   // behavioural reference state
   int a_div = 0, a_pre = 0, cnt = 0, ticks = 0;
   bit e_tick = 0, e_bit = 0;
   int cyc = 0;
   int exp_gap = 0;
   int last_t = 0, last_b = 0;
   bit have_t = 0, have_b = 0;

   always #4 clk = ~clk;   // 125 MHz

   ovs_baud_gen uut (
      .clk(clk), .rst_n(rst_n), .div_val(dv), .pre_val(pv),
      .cfg_lock(lock), .sample_tick(sample_tick), .bit_stb(bit_stb)
   );

   task automatic fail(input string req, input string what, input int act, input int exp);
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
   endtask

   // reference model and per-clock comparison
   always @(posedge clk) begin
      int n;
      if (!rst_n) begin
         a_div = 0; a_pre = 0; cnt = 0; ticks = 0; e_tick = 0; e_bit = 0;
      end else if (!lock && (int'(dv) != a_div || int'(pv) != a_pre)) begin
         a_div = dv; a_pre = pv; cnt = 0; ticks = 0; e_tick = 0; e_bit = 0;
      end else if (a_div == 0) begin
         e_tick = 0; e_bit = 0;
      end else begin
         n = a_div * ((a_pre == 0) ? 1 : a_pre);
         cnt++;
         if (cnt == n) begin
            cnt = 0; ticks++; e_tick = 1; e_bit = (ticks % 16 == 0);
         end else begin
            e_tick = 0; e_bit = 0;
         end
      end
      cyc++;
      #2;
      checks++;
      if (sample_tick !== e_tick) fail(cur, "sample_tick", sample_tick, e_tick);
      checks++;
      if (bit_stb !== e_bit) fail(cur, "bit_stb", bit_stb, e_bit);
      if (sample_tick === 1'b1) begin
         if (have_t && exp_gap > 0) begin
            checks++;
            if (cyc - last_t != exp_gap) fail({cur, "/R2"}, "tick gap", cyc - last_t, exp_gap);
         end
         last_t = cyc; have_t = 1;
      end
      if (bit_stb === 1'b1) begin
         if (have_b && exp_gap > 0) begin
            checks++;
            if (cyc - last_b != 16 * exp_gap) fail({cur, "/R3"}, "bit gap", cyc - last_b, 16 * exp_gap);
         end
         last_b = cyc; have_b = 1;
      end
   end

   task automatic apply(input int d, input int p, input string tag, input int gap);
      @(negedge clk);
      dv = 16'(d); pv = 4'(p); cur = tag; exp_gap = gap;
      have_t = 0; have_b = 0;
   endtask

   // edges from the value change until the first tick; the capture edge counts as 1
   task automatic latency(input int n, input string tag);
      int k = 0;
      do begin
         @(posedge clk); #3; k++;
      end while (sample_tick !== 1'b1 && k < n + 5);
      checks++;
      if (k != n + 1) fail(tag, "first tick latency", k, n + 1);
   endtask

   task automatic expect_silent(input int m, input string tag);
      int seen = 0;
      for (int i = 0; i < m; i++) begin
         @(posedge clk); #3;
         if (sample_tick === 1'b1 || bit_stb === 1'b1) seen++;
      end
      checks++;
      if (seen != 0) fail(tag, "pulses while stopped", seen, 0);
   endtask

   task automatic run(input int m);
      repeat (m) @(posedge clk);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      // R1: reset state
      dv = 16'd3; pv = 4'd2;
      repeat (3) @(negedge clk);
      checks++;
      if (sample_tick !== 1'b0 || bit_stb !== 1'b0)
         fail("R1", "outputs in reset", {sample_tick, bit_stb}, 0);
      dv = '0; pv = '0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (sample_tick !== 1'b0 || bit_stb !== 1'b0)
         fail("R1", "outputs after reset", {sample_tick, bit_stb}, 0);

      // R4: zero divisor with a non-zero prescaler stays silent
      apply(0, 3, "R4", 0);
      expect_silent(60, "R4");

      // R2/R3: divisor 3, prescaler 2 -> 6 clocks per tick
      apply(3, 2, "R2", 6);
      latency(6, "R2");
      run(300);

      // R5: prescaler zero behaves as one
      apply(5, 0, "R5", 5);
      latency(5, "R5");
      run(200);

      // R8: full rate
      apply(1, 1, "R8", 1);
      latency(1, "R8");
      run(60);

      // R6: reload mid-period
      apply(4, 3, "R6", 12);
      run(30);
      apply(2, 1, "R6", 2);
      latency(2, "R6");
      run(80);

      // R7: changes while locked are held back
      apply(4, 3, "R7", 12);
      run(100);
      @(negedge clk); lock = 1'b1;
      @(negedge clk); dv = 16'd7; pv = 4'd2;
      run(150);
      @(negedge clk); lock = 1'b0; exp_gap = 14; have_t = 0; have_b = 0;
      latency(14, "R7");
      run(250);

      // R4: divisor set back to zero stops a running generator
      apply(0, 2, "R4", 0);
      @(posedge clk);
      expect_silent(80, "R4");

      // R1: reset during operation
      apply(2, 2, "R1", 4);
      run(40);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      checks++;
      if (sample_tick !== 1'b0 || bit_stb !== 1'b0)
         fail("R1", "outputs in mid-run reset", {sample_tick, bit_stb}, 0);
      dv = '0; pv = '0;
      @(negedge clk); rst_n = 1'b1;
      run(5);

      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
   end
endmodule